// File: doc/BRIEF.md
# Descriptor Chain DMA Channel

This block is one DMA channel that follows a linked list of buffer descriptors kept in a small local descriptor RAM. Software builds descriptors through a RAM port, then starts the channel by writing the address of the first descriptor to the head pointer register. The channel fetches each descriptor, runs the payload move (modelled by a fixed-latency stub), writes back a completed mode word, reports the finished descriptor's address in the completion pointer and pulses an event. It then moves on to the next descriptor.

A descriptor that software does not own stops the walk. A descriptor with a zero next pointer ends it and is marked end-of-queue. Software can therefore see that an append arrived too late and restart the channel with a new head write. A teardown request stops the walk at the next descriptor boundary. The channel then writes a fixed marker into the completion pointer and waits until software writes that marker back.

Top module: `dchain_dma_chan`

## Requirements
- R1: After reset the completion pointer reads 0, no event is pulsed and the busy-write error flag is 0; writing 0 to the head pointer leaves the channel idle, with no descriptor processed and no event.
- R2: A nonzero head pointer write while idle starts processing at that descriptor. Descriptors are handled in next-pointer order. Each completion loads that descriptor's address into the completion pointer and pulses the event for exactly one cycle, together with the new value.
- R3: If a fetched descriptor has mode bit 29 (owned by hardware) at 0, the channel stops without an event, leaves the descriptor unchanged and keeps the completion pointer.
- R4: On completion the mode word is written back as follows. Bit 29 is cleared and bit 27 is 0. Bits 31, 30, 20 and 18..16 keep their values. Bits 10..0 hold the reported length, which is the low 11 bits of the length word.
- R5: When a completed descriptor has a next pointer of 0, its mode bit 28 (end of queue) is set and the channel goes idle; otherwise bit 28 is 0. A later head write restarts the channel.
- R6: With keep_crc high, the reported length is the buffer length plus 4, saturated at 2047, and mode bit 26 is set. With keep_crc low, bit 26 is written 0.
- R7: A head pointer write while the channel is not idle is ignored and sets head_err. head_err stays set until the next write to the completion pointer.
- R8: A teardown request (reg_sel 2) takes effect at the next descriptor boundary. The descriptor fetched next has bit 29 cleared, bits 28 and 27 set, bit 26 and bits 10..0 zeroed, and no transfer is made for it. The completion pointer becomes 0xFFFFFFFC and one event pulses. When the request arrives while idle, the marker and the event follow with no descriptor written.
- R9: A software write to the completion pointer (reg_sel 1) loads that value. After a teardown the channel refuses head writes until the value written is 0xFFFFFFFC, which returns it to idle.
- R10: Descriptor i sits at RAM words 4i..4i+3, holding next pointer, buffer address, length and mode in that order. Its pointer is the byte address 16·i, so index 0 cannot be linked, because pointer 0 means end of list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keep_crc | input | 1 | Report lengths with the 4 CRC bytes and flag it in the mode word |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 head pointer, 1 completion pointer, 2 teardown, 3 no effect |
| reg_wdata | input | 32 | Register write value |
| ram_we | input | 1 | Descriptor RAM write strobe |
| ram_addr | input | $clog2(NDESC)+2 | Descriptor RAM word address |
| ram_wdata | input | 32 | Descriptor RAM write data |
| ram_rdata | output | 32 | Descriptor RAM read data, one cycle after the address |
| cp_value | output | 32 | Completion pointer |
| irq_evt | output | 1 | One-cycle event per returned descriptor or finished teardown |
| head_err | output | 1 | Sticky flag for a refused head pointer write |

## Verification
The walk is driven with a three-descriptor chain of varied lengths and port bits, a single-descriptor restart after end of queue, a head that software still owns, and a CRC-keeping pair whose second length saturates. Together these separate ordering, ownership, length arithmetic and end-of-queue marking. A head write made mid-chain shows that the refused descriptor stays untouched and that the running chain does not change. A teardown issued during a fetch and one issued while idle show the difference between marking a descriptor and writing only the marker. Non-marker and marker acknowledgements show that only the marker releases the channel.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  localparam int BIT_OWN = 29;
  localparam int BIT_EOQ = 28;
  localparam int BIT_TDC = 27;
  localparam int BIT_CRC = 26;

  localparam logic [31:0] TD_MARKER = 32'hFFFF_FFFC;

  localparam logic [1:0] SEL_HEAD = 2'd0;
  localparam logic [1:0] SEL_CPTR = 2'd1;
  localparam logic [1:0] SEL_TDWN = 2'd2;

  // word offsets inside one descriptor
  localparam logic [1:0] OFS_NEXT = 2'd0;
  localparam logic [1:0] OFS_LEN  = 2'd2;
  localparam logic [1:0] OFS_MODE = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_XFER, S_WB, S_TDMARK, S_TDWAIT
  } eng_state_t;

  // length reported back in the mode word, saturating at 11 bits
  function automatic logic [10:0] report_len(input logic [10:0] buflen,
                                             input logic keep);
    logic [11:0] sum;
    sum = {1'b0, buflen} + (keep ? 12'd4 : 12'd0);
    return sum[11] ? 11'h7FF : sum[10:0];
  endfunction

  function automatic logic [31:0] done_mode(input logic [31:0] orig,
                                            input logic [10:0] len,
                                            input logic last,
                                            input logic keep);
    logic [31:0] m;
    m = orig;
    m[BIT_OWN] = 1'b0;
    m[BIT_EOQ] = last;
    m[BIT_TDC] = 1'b0;
    m[BIT_CRC] = keep;
    m[10:0] = len;
    return m;
  endfunction

  function automatic logic [31:0] td_mode(input logic [31:0] orig);
    logic [31:0] m;
    m = orig;
    m[BIT_OWN] = 1'b0;
    m[BIT_EOQ] = 1'b1;
    m[BIT_TDC] = 1'b1;
    m[BIT_CRC] = 1'b0;
    m[10:0] = 11'd0;
    return m;
  endfunction

endpackage

// File: rtl/dchain_desc_ram.sv
module dchain_desc_ram #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [31:0]   eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [31:0]   eng_wdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (sw_we) mem[sw_addr] <= sw_wdata;
    if (eng_we) mem[eng_waddr] <= eng_wdata;  // engine wins on a clash
    sw_rdata  <= mem[sw_addr];
    eng_rdata <= mem[eng_raddr];
  end
endmodule

// File: rtl/dchain_xfer_stub.sv
module dchain_xfer_stub #(
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(LAT);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));
endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
  import dchain_pkg::*;
#(
  parameter int NDESC = 16,
  localparam int IDX_W = $clog2(NDESC),
  localparam int WA_W = IDX_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            keep_crc,
  input  logic            head_wr,
  input  logic            cp_wr,
  input  logic            td_wr,
  input  logic [31:0]     wdata,
  output logic [WA_W-1:0] rd_addr,
  input  logic [31:0]     rd_data,
  output logic            mode_wr,
  output logic [WA_W-1:0] mode_wr_addr,
  output logic [31:0]     mode_wr_data,
  output logic            xfer_start,
  input  logic            xfer_done,
  output logic [31:0]     cp_value,
  output logic            irq_evt,
  output logic            head_err,
  output logic            eng_idle,
  output logic            td_done
);
  eng_state_t       state;
  logic [1:0]       fc;
  logic [31:0]      cur_ptr;
  logic [31:0]      nxt_q;
  logic [10:0]      len_q;
  logic [31:0]      mode_q;
  logic             td_pend;
  logic [IDX_W-1:0] cur_idx;
  logic             head_go;
  logic [1:0]       rd_ofs;

  assign cur_idx  = cur_ptr[IDX_W+3:4];
  assign head_go  = head_wr && (wdata != 32'd0);
  assign eng_idle = (state == S_IDLE);

  always_comb begin
    case (fc)
      2'd0:    rd_ofs = OFS_NEXT;
      2'd1:    rd_ofs = OFS_LEN;
      default: rd_ofs = OFS_MODE;
    endcase
  end
  assign rd_addr = {cur_idx, rd_ofs};

  assign mode_wr      = (state == S_WB) || (state == S_TDMARK);
  assign mode_wr_addr = {cur_idx, OFS_MODE};
  assign mode_wr_data = (state == S_TDMARK) ? td_mode(mode_q)
                      : done_mode(mode_q, report_len(len_q, keep_crc),
                                  nxt_q == 32'd0, keep_crc);
  assign xfer_start   = (state == S_DECIDE) && !td_pend && mode_q[BIT_OWN];
  assign td_done      = (state == S_TDMARK) ||
                        ((state == S_IDLE) && !head_go && td_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fc       <= '0;
      cur_ptr  <= '0;
      nxt_q    <= '0;
      len_q    <= '0;
      mode_q   <= '0;
      cp_value <= '0;
      irq_evt  <= 1'b0;
      head_err <= 1'b0;
      td_pend  <= 1'b0;
    end else begin
      irq_evt <= 1'b0;
      if (cp_wr) begin
        cp_value <= wdata;
        head_err <= 1'b0;
      end
      if (head_wr && state != S_IDLE) head_err <= 1'b1;
      if (td_wr && state != S_TDWAIT) td_pend <= 1'b1;

      case (state)
        S_IDLE: begin
          if (head_go) begin
            cur_ptr <= wdata;
            fc      <= '0;
            state   <= S_FETCH;
          end else if (td_pend) begin
            cp_value <= TD_MARKER;
            irq_evt  <= 1'b1;
            td_pend  <= 1'b0;
            state    <= S_TDWAIT;
          end
        end
        S_FETCH: begin
          fc <= fc + 2'd1;
          case (fc)
            2'd1: nxt_q <= rd_data;
            2'd2: len_q <= rd_data[10:0];
            2'd3: begin
              mode_q <= rd_data;
              state  <= S_DECIDE;
            end
            default: ;
          endcase
        end
        S_DECIDE: begin
          if (td_pend) state <= S_TDMARK;
          else if (mode_q[BIT_OWN]) state <= S_XFER;
          else state <= S_IDLE;
        end
        S_XFER: begin
          if (xfer_done) state <= S_WB;
        end
        S_WB: begin
          cp_value <= cur_ptr;
          irq_evt  <= 1'b1;
          if (nxt_q == 32'd0) begin
            state <= S_IDLE;
          end else begin
            cur_ptr <= nxt_q;
            fc      <= '0;
            state   <= S_FETCH;
          end
        end
        S_TDMARK: begin
          cp_value <= TD_MARKER;
          irq_evt  <= 1'b1;
          td_pend  <= 1'b0;
          state    <= S_TDWAIT;
        end
        S_TDWAIT: begin
          if (cp_wr && wdata == TD_MARKER) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_dma_chan.sv
module dchain_dma_chan
  import dchain_pkg::*;
#(
  parameter int NDESC = 16,
  parameter int XFER_LAT = 4,
  localparam int RAM_AW = $clog2(NDESC) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep_crc,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              ram_we,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [31:0]       ram_wdata,
  output logic [31:0]       ram_rdata,
  output logic [31:0]       cp_value,
  output logic              irq_evt,
  output logic              head_err
);
  localparam int WORDS = NDESC * 4;

  logic              head_wr, cp_wr, td_wr;
  logic [RAM_AW-1:0] eng_raddr, mode_wr_addr;
  logic [31:0]       eng_rdata, mode_wr_data;
  logic              mode_wr, xfer_start, xfer_done, eng_idle, td_done;

  assign head_wr = reg_we && (reg_sel == SEL_HEAD);
  assign cp_wr   = reg_we && (reg_sel == SEL_CPTR);
  assign td_wr   = reg_we && (reg_sel == SEL_TDWN);

  dchain_desc_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .sw_we(ram_we), .sw_addr(ram_addr), .sw_wdata(ram_wdata),
    .sw_rdata(ram_rdata), .eng_raddr(eng_raddr), .eng_rdata(eng_rdata),
    .eng_we(mode_wr), .eng_waddr(mode_wr_addr), .eng_wdata(mode_wr_data)
  );

  dchain_xfer_stub #(.LAT(XFER_LAT)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .done(xfer_done)
  );

  dchain_engine #(.NDESC(NDESC)) u_eng (
    .clk(clk), .rst_n(rst_n), .keep_crc(keep_crc),
    .head_wr(head_wr), .cp_wr(cp_wr), .td_wr(td_wr), .wdata(reg_wdata),
    .rd_addr(eng_raddr), .rd_data(eng_rdata),
    .mode_wr(mode_wr), .mode_wr_addr(mode_wr_addr), .mode_wr_data(mode_wr_data),
    .xfer_start(xfer_start), .xfer_done(xfer_done),
    .cp_value(cp_value), .irq_evt(irq_evt), .head_err(head_err),
    .eng_idle(eng_idle), .td_done(td_done)
  );
endmodule

// File: rtl/dchain_dma_chan_chk.sv
module dchain_dma_chan_chk
  import dchain_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        keep_crc,
  input logic        head_wr,
  input logic        irq_evt,
  input logic [31:0] cp_value,
  input logic        head_err,
  input logic        mode_wr,
  input logic [31:0] mode_wr_data,
  input logic        eng_idle,
  input logic        td_done,
  input logic        xfer_done
);
  // R2: the event is a single-cycle pulse
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> !irq_evt);

  // R2: a normal write-back is preceded by the payload stub finishing
  p_wb_after_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !mode_wr_data[BIT_TDC]) |-> $past(xfer_done));

  // R4: the write-back returns ownership to software
  p_owner_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> !mode_wr_data[BIT_OWN]);

  // R5: an end-of-queue write-back leaves the channel idle
  p_eoq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wr_data[BIT_EOQ] && !mode_wr_data[BIT_TDC]) |=> eng_idle);

  // R6: a kept CRC is flagged in the completed mode word
  p_crc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && keep_crc && !mode_wr_data[BIT_TDC]) |-> mode_wr_data[BIT_CRC]);

  // R7: a head write outside idle raises the error flag
  p_busy_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_wr && !eng_idle) |=> head_err);

  // R8: teardown completion shows the marker with one event
  p_td_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    td_done |=> (irq_evt && cp_value == TD_MARKER));
endmodule

bind dchain_dma_chan dchain_dma_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .keep_crc(keep_crc), .head_wr(head_wr),
  .irq_evt(irq_evt), .cp_value(cp_value), .head_err(head_err),
  .mode_wr(mode_wr), .mode_wr_data(mode_wr_data), .eng_idle(eng_idle),
  .td_done(td_done), .xfer_done(xfer_done)
);

// File: tb/dchain_dma_chan_bench.sv
module dchain_dma_chan_bench;
  localparam int NDESC = 16;
  localparam int AW = $clog2(NDESC) + 2;
  localparam logic [31:0] MARK = 32'hFFFF_FFFC;
  localparam logic [31:0] BASE = 32'hE013_0000; // sop, eop, owned, directed port 3
  localparam logic [31:0] NOWN = 32'hC005_0000; // sop, eop, not owned, port 5

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          keep_crc = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd3;
  logic [31:0]   reg_wdata = '0;
  logic          ram_we = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [31:0]   ram_wdata = '0;
  logic [31:0]   ram_rdata, cp_value;
  logic          irq_evt, head_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dchain_dma_chan #(.NDESC(NDESC), .XFER_LAT(4)) u_dchain_dma_chan (
    .clk(clk), .rst_n(rst_n), .keep_crc(keep_crc), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .cp_value(cp_value), .irq_evt(irq_evt), .head_err(head_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_done(input logic [31:0] orig,
      input int blen, input bit last, input bit crc);
    int l;
    l = crc ? blen + 4 : blen;
    if (l > 2047) l = 2047;
    return (orig & 32'hC3FF_F800) | (last ? 32'h1000_0000 : 32'h0) |
           (crc ? 32'h0400_0000 : 32'h0) | 32'(l);
  endfunction

  function automatic logic [31:0] exp_td(input logic [31:0] orig);
    return (orig & 32'hC3FF_F800) | 32'h1800_0000;
  endfunction

  task automatic put_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic put_word(input int addr, input logic [31:0] val);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = AW'(addr); ram_wdata = val;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic get_word(input int addr, output logic [31:0] val);
    @(negedge clk);
    ram_addr = AW'(addr);
    @(negedge clk);
    val = ram_rdata;
  endtask

  // R10: layout next, buffer, length, mode at words 4i..4i+3; pointer 16*i
  task automatic make_desc(input int idx, input int nxt, input int blen,
                           input logic [31:0] mode);
    put_word(idx * 4 + 0, 32'(nxt * 16));
    put_word(idx * 4 + 1, 32'(idx * 256));
    put_word(idx * 4 + 2, 32'(blen));
    put_word(idx * 4 + 3, mode);
  endtask

  task automatic expect_cp(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain(input int n, input string tag);
    repeat (n) @(negedge clk);
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic check_mode(input int idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    get_word(idx * 4 + 3, v);
    check(v === exp, tag, v, exp);
  endtask

  // scoreboard monitor: each event must match the next expected pointer
  always @(negedge clk) begin
    if (rst_n && irq_evt) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected event", cp_value, 32'hX);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cp_value === e, t, cp_value, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cp_value === 32'd0, "R1 cp after reset", cp_value, 32'd0);
    check(irq_evt === 1'b0, "R1 event after reset", 32'(irq_evt), 32'd0);
    check(head_err === 1'b0, "R1 err after reset", 32'(head_err), 32'd0);
    put_reg(2'd0, 32'd0);
    drain(40, "R1 zero head stays idle");
    check(head_err === 1'b0, "R1 zero head no err", 32'(head_err), 32'd0);

    // R2 R4 R5: three-descriptor chain
    make_desc(1, 2, 60, BASE);
    make_desc(2, 3, 1500, BASE | 32'h0000_0400);
    make_desc(3, 0, 7, 32'h6012_0000);
    expect_cp(32'd16, "R2 cp desc1");
    expect_cp(32'd32, "R2 cp desc2");
    expect_cp(32'd48, "R2 cp desc3");
    put_reg(2'd0, 32'd16);
    drain(150, "R2 chain events");
    check_mode(1, exp_done(BASE, 60, 0, 0), "R4 desc1 mode");
    check_mode(2, exp_done(BASE | 32'h0000_0400, 1500, 0, 0), "R4 desc2 mode");
    check_mode(3, exp_done(32'h6012_0000, 7, 1, 0), "R5 desc3 eoq");

    // R5 restart after end of queue
    make_desc(4, 0, 64, BASE);
    expect_cp(32'd64, "R5 restart cp");
    put_reg(2'd0, 32'd64);
    drain(60, "R5 restart events");
    check_mode(4, exp_done(BASE, 64, 1, 0), "R5 restart mode");

    // R3 head not owned by hardware
    make_desc(9, 4, 33, NOWN);
    put_reg(2'd0, 32'd144);
    drain(60, "R3 no event");
    check_mode(9, NOWN, "R3 mode untouched");
    check(cp_value === 32'd64, "R3 cp kept", cp_value, 32'd64);

    // R6 CRC kept, with saturation
    keep_crc = 1'b1;
    make_desc(10, 11, 100, BASE);
    make_desc(11, 0, 2046, BASE);
    expect_cp(32'd160, "R6 cp desc10");
    expect_cp(32'd176, "R6 cp desc11");
    put_reg(2'd0, 32'd160);
    drain(100, "R6 events");
    check_mode(10, exp_done(BASE, 100, 0, 1), "R6 len plus 4");
    check_mode(11, exp_done(BASE, 2046, 1, 1), "R6 len saturates");
    keep_crc = 1'b0;

    // R7 head write while busy
    make_desc(1, 2, 20, BASE);
    make_desc(2, 0, 21, BASE);
    make_desc(5, 0, 22, BASE);
    expect_cp(32'd16, "R7 cp desc1");
    expect_cp(32'd32, "R7 cp desc2");
    put_reg(2'd0, 32'd16);
    put_reg(2'd0, 32'd80);
    drain(100, "R7 chain unaffected");
    check(head_err === 1'b1, "R7 err set", 32'(head_err), 32'd1);
    check_mode(5, BASE | 32'd0, "R7 refused desc untouched");
    put_reg(2'd1, 32'd0);
    @(negedge clk);
    check(head_err === 1'b0, "R7 err cleared", 32'(head_err), 32'd0);
    check(cp_value === 32'd0, "R9 cp software write", cp_value, 32'd0);

    // R8 teardown during a fetch
    make_desc(6, 7, 40, BASE);
    make_desc(7, 0, 41, BASE);
    expect_cp(MARK, "R8 marker");
    put_reg(2'd0, 32'd96);
    put_reg(2'd2, 32'd0);
    drain(60, "R8 one event");
    check_mode(6, exp_td(BASE), "R8 torn desc mode");
    check_mode(7, BASE, "R8 next desc untouched");

    // R9 torn channel refuses head until marker ack
    make_desc(12, 0, 50, BASE);
    put_reg(2'd0, 32'd192);
    drain(40, "R9 head refused");
    check(head_err === 1'b1, "R9 err on refused head", 32'(head_err), 32'd1);
    put_reg(2'd1, 32'h1234_5670);
    @(negedge clk);
    check(cp_value === 32'h1234_5670, "R9 cp loads value", cp_value, 32'h1234_5670);
    put_reg(2'd0, 32'd192);
    drain(40, "R9 still torn");
    check_mode(12, BASE, "R9 desc untouched while torn");
    put_reg(2'd1, MARK);
    expect_cp(32'd192, "R9 after ack");
    put_reg(2'd0, 32'd192);
    drain(60, "R9 ack releases");
    check_mode(12, exp_done(BASE, 50, 1, 0), "R9 desc done after ack");

    // R8 teardown while idle
    expect_cp(MARK, "R8 idle marker");
    put_reg(2'd2, 32'd0);
    drain(20, "R8 idle event");
    put_reg(2'd1, MARK);
    expect_cp(32'd256 - 16, "R8 idle release");
    make_desc(15, 0, 9, BASE);
    put_reg(2'd0, 32'd240);
    drain(60, "R8 idle released");

    finish_run();
  end
endmodule